// File: doc/BRIEF.md
# Transceiver Management Register Block with Digital Reset Sequencer

This block is the control-plane slave for a multi-channel serial transceiver. A management master reaches it through a word-addressed port with 32-bit write and read data and separate read and write strobes. One flat address space holds four registers. The first is a read-only word that shows which transmit PLLs are locked. The second holds one calibration power-down bit per channel. The third is a per-channel reset mask. The fourth is a reset control word.

Writing the control word does not store a value. A 1 in the transmit or receive start bit begins a timed digital reset. Every channel enabled in the mask at the time of the write has its reset output driven high for a fixed number of clocks. Channels outside the mask keep their reset outputs low. Reading the same address returns the sequencer's ready flags rather than any stored data. A flag is high only when its direction has no reset in progress and every PLL reports lock.

Top module: `xcvr_mgmt_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its idle state. After that edge the channel mask is all ones, `cal_pd` is 0, both reset output vectors are 0 and `mgmt_rdata` is 0.
- R2: Read data is registered. A read strobe at clock edge k puts the addressed value on `mgmt_rdata` after edge k. After any edge with no read strobe, `mgmt_rdata` is 0. Reads of unmapped addresses return 0.
- R3: Address 0x021 is read-only. Bit P of the read value equals `pll_locked[P]`, and the higher bits are 0. Writes to 0x021 change nothing.
- R4: Address 0x022 holds the calibration power-down bits. A write copies `mgmt_wdata[NUM_CH-1:0]` to `cal_pd` in the next cycle, and a read returns the same value.
- R5: Address 0x041 holds the channel reset mask, bit n for channel n. A write stores `mgmt_wdata[NUM_CH-1:0]`, and a read returns the stored value.
- R6: A write to 0x042 with data bit 0 set drives `tx_digital_rst` to the mask value held before that write. This lasts exactly RST_CYCLES cycles, starting in the cycle after the write. Unmasked channels stay low throughout.
- R7: A write to 0x042 with data bit 1 set does the same on `rx_digital_rst`. Setting both bits starts both directions together, and each direction is independent of the other.
- R8: A read of 0x042 returns the TX-ready flag in bit 0 and the RX-ready flag in bit 1. A flag is 1 only when its direction has no reset in progress and all `pll_locked` bits are 1.
- R9: A start request that arrives while that direction is still running restarts its count at full length. It also takes the channel set from the mask as it stands at the time of the new write.
- R10: Writes to unmapped addresses change no register and no output.
- R11: A write to 0x042 with bits 0 and 1 both clear starts nothing, whatever the other data bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high global reset |
| mgmt_addr | input | ADDR_W | Word address |
| mgmt_wdata | input | DATA_W | Write data |
| mgmt_write | input | 1 | Write strobe |
| mgmt_read | input | 1 | Read strobe |
| mgmt_rdata | output | DATA_W | Registered read data |
| pll_locked | input | NUM_PLL | Lock indication per transmit PLL |
| cal_pd | output | NUM_CH | Per-channel calibration power-down |
| tx_digital_rst | output | NUM_CH | Per-channel TX digital reset |
| rx_digital_rst | output | NUM_CH | Per-channel RX digital reset |

## Verification
The bench builds the block with four channels, two PLLs and a reset length of five cycles. With two PLLs, the ready flags can be shown to need every PLL locked, not just one. The short reset length lets the bench cover several full sequences, a restart in mid-sequence with a narrower mask, and a run with an empty mask, all in a few hundred cycles. With four channels, sparse masks such as 0x5 and 0x3 show that unselected channels stay low.

// File: rtl/xcvr_mgmt_pkg.sv
package xcvr_mgmt_pkg;

  localparam int unsigned MGMT_ADDR_W = 9;
  localparam int unsigned MGMT_DATA_W = 32;

  // Word addresses of the register file
  localparam int unsigned ADR_PLL_STAT = 'h021;
  localparam int unsigned ADR_CAL_PD   = 'h022;
  localparam int unsigned ADR_CH_MASK  = 'h041;
  localparam int unsigned ADR_RST_CTRL = 'h042;

  // Sequencer directions, also the start-bit positions in the control word
  localparam int unsigned DIR_TX  = 0;
  localparam int unsigned DIR_RX  = 1;
  localparam int unsigned NUM_DIR = 2;

  typedef struct packed {
    logic pll_stat;
    logic cal_pd;
    logic ch_mask;
    logic rst_ctrl;
  } reg_sel_t;

endpackage

// File: rtl/xcvr_mgmt_dec.sv
module xcvr_mgmt_dec
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = MGMT_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  always_comb begin
    sel          = '0;
    sel.pll_stat = (addr == ADDR_W'(ADR_PLL_STAT));
    sel.cal_pd   = (addr == ADDR_W'(ADR_CAL_PD));
    sel.ch_mask  = (addr == ADDR_W'(ADR_CH_MASK));
    sel.rst_ctrl = (addr == ADDR_W'(ADR_RST_CTRL));
  end

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              locked_all,
  output logic [NUM_CH-1:0] rst_out,
  output logic              busy,
  output logic              ready
);

  localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0] out_q;
  logic              busy_q;

  // The load of RST_CYCLES-1 plus the cycle of the load itself gives RST_CYCLES cycles high
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      out_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CNT_LOAD;
      out_q  <= ch_mask;
      busy_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      out_q  <= '0;
      busy_q <= 1'b0;
    end
  end

  assign rst_out = out_q;
  assign busy    = busy_q;
  assign ready   = ~busy_q & locked_all;

endmodule

// File: rtl/xcvr_mgmt_rdmux.sv
module xcvr_mgmt_rdmux
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W  = MGMT_DATA_W,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_PLL = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  reg_sel_t           sel,
  input  logic [NUM_PLL-1:0] pll_locked,
  input  logic [NUM_CH-1:0]  cal_pd,
  input  logic [NUM_CH-1:0]  ch_mask,
  input  logic [NUM_DIR-1:0] ready,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      sel.pll_stat: rd_val = DATA_W'(pll_locked);
      sel.cal_pd:   rd_val = DATA_W'(cal_pd);
      sel.ch_mask:  rd_val = DATA_W'(ch_mask);
      sel.rst_ctrl: rd_val = DATA_W'(ready);
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
    else         rdata <= '0;
  end

endmodule

// File: rtl/xcvr_mgmt_regs.sv
module xcvr_mgmt_regs
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W     = MGMT_ADDR_W,
  parameter int unsigned DATA_W     = MGMT_DATA_W,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_PLL    = 1,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  mgmt_addr,
  input  logic [DATA_W-1:0]  mgmt_wdata,
  input  logic               mgmt_write,
  input  logic               mgmt_read,
  output logic [DATA_W-1:0]  mgmt_rdata,
  input  logic [NUM_PLL-1:0] pll_locked,
  output logic [NUM_CH-1:0]  cal_pd,
  output logic [NUM_CH-1:0]  tx_digital_rst,
  output logic [NUM_CH-1:0]  rx_digital_rst
);

  reg_sel_t          sel;
  logic [NUM_CH-1:0] cal_q;
  logic [NUM_CH-1:0] mask_q;
  logic              locked_all;
  logic              ctrl_wr;

  logic [NUM_CH-1:0]  rst_vec   [NUM_DIR];
  logic [NUM_DIR-1:0] busy_vec;
  logic [NUM_DIR-1:0] ready_vec;

  xcvr_mgmt_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (mgmt_addr),
    .sel  (sel)
  );

  // Writable registers; the PLL status word has no storage
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q  <= '0;
      mask_q <= '1;
    end else if (mgmt_write) begin
      if (sel.cal_pd)  cal_q  <= mgmt_wdata[NUM_CH-1:0];
      if (sel.ch_mask) mask_q <= mgmt_wdata[NUM_CH-1:0];
    end
  end

  assign locked_all = &pll_locked;
  assign ctrl_wr    = mgmt_write & sel.rst_ctrl;

  // One sequencer per direction, started by its own bit of the control word
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_rst_seq #(
      .NUM_CH     (NUM_CH),
      .RST_CYCLES (RST_CYCLES)
    ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (ctrl_wr & mgmt_wdata[d]),
      .ch_mask    (mask_q),
      .locked_all (locked_all),
      .rst_out    (rst_vec[d]),
      .busy       (busy_vec[d]),
      .ready      (ready_vec[d])
    );
  end

  xcvr_mgmt_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_CH  (NUM_CH),
    .NUM_PLL (NUM_PLL)
  ) u_rdmux (
    .clk        (clk),
    .rst        (rst),
    .rd         (mgmt_read),
    .sel        (sel),
    .pll_locked (pll_locked),
    .cal_pd     (cal_q),
    .ch_mask    (mask_q),
    .ready      (ready_vec),
    .rdata      (mgmt_rdata)
  );

  assign cal_pd         = cal_q;
  assign tx_digital_rst = rst_vec[DIR_TX];
  assign rx_digital_rst = rst_vec[DIR_RX];

endmodule

// File: rtl/xcvr_mgmt_chk.sv
module xcvr_mgmt_chk
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = MGMT_ADDR_W,
  parameter int unsigned DATA_W = MGMT_DATA_W,
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [DATA_W-1:0] mgmt_wdata,
  input logic              mgmt_write,
  input logic              mgmt_read,
  input logic [DATA_W-1:0] mgmt_rdata,
  input logic [NUM_CH-1:0] cal_pd,
  input logic [NUM_CH-1:0] tx_rst,
  input logic [NUM_CH-1:0] rx_rst,
  input logic [NUM_CH-1:0] mask_q,
  input logic              tx_ready,
  input logic              rx_ready
);

  logic ctrl_hit;
  assign ctrl_hit = mgmt_write && (mgmt_addr == ADDR_W'(ADR_RST_CTRL));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && cal_pd == '0 && tx_rst == '0 && rx_rst == '0 && mgmt_rdata == '0));

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
    !mgmt_read |=> mgmt_rdata == '0);

  assert_cal_write_R4: assert property (@(posedge clk) disable iff (rst)
    (mgmt_write && mgmt_addr == ADDR_W'(ADR_CAL_PD)) |=> cal_pd == $past(mgmt_wdata[NUM_CH-1:0]));

  assert_tx_start_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && mgmt_wdata[DIR_TX]) |=> tx_rst == $past(mask_q));

  assert_tx_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ((tx_rst & ~$past(tx_rst)) != '0) |-> $past(ctrl_hit && mgmt_wdata[DIR_TX]));

  assert_rx_start_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && mgmt_wdata[DIR_RX]) |=> rx_rst == $past(mask_q));

  assert_ready_low_R8: assert property (@(posedge clk) disable iff (rst)
    ((tx_rst != '0) |-> !tx_ready) and ((rx_rst != '0) |-> !rx_ready));

endmodule

bind xcvr_mgmt_regs xcvr_mgmt_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mgmt_addr  (mgmt_addr),
  .mgmt_wdata (mgmt_wdata),
  .mgmt_write (mgmt_write),
  .mgmt_read  (mgmt_read),
  .mgmt_rdata (mgmt_rdata),
  .cal_pd     (cal_pd),
  .tx_rst     (tx_digital_rst),
  .rx_rst     (rx_digital_rst),
  .mask_q     (mask_q),
  .tx_ready   (ready_vec[0]),
  .rx_ready   (ready_vec[1])
);

// File: tb/tb_xcvr_mgmt_regs.sv
`timescale 1ns/1ps
module tb_xcvr_mgmt_regs;

  localparam int NCH = 4;
  localparam int NPLL = 2;
  localparam int NRST = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  mgmt_addr = '0;
  logic [31:0] mgmt_wdata = '0;
  logic        mgmt_write = 1'b0;
  logic        mgmt_read = 1'b0;
  logic [31:0] mgmt_rdata;
  logic [NPLL-1:0] pll_locked = '1;
  logic [NCH-1:0]  cal_pd, tx_digital_rst, rx_digital_rst;

  int nchecks = 0;
  int nerr = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcvr_mgmt_regs #(.NUM_CH(NCH), .NUM_PLL(NPLL), .RST_CYCLES(NRST)) dut (
    .clk(clk), .rst(rst), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_write(mgmt_write), .mgmt_read(mgmt_read), .mgmt_rdata(mgmt_rdata),
    .pll_locked(pll_locked), .cal_pd(cal_pd),
    .tx_digital_rst(tx_digital_rst), .rx_digital_rst(rx_digital_rst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_tx_left = 0, m_rx_left = 0;
  logic [NCH-1:0] m_mask = '1, m_cal = '0, m_txset = '0, m_rxset = '0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    logic [NCH-1:0] old_mask;
    logic [31:0] rv;
    if (rst) begin
      m_tx_left = 0; m_rx_left = 0; m_mask = '1; m_cal = '0; m_rdata = '0;
    end else begin
      old_mask = m_mask;
      rv = 0;
      if (mgmt_read) begin
        case (mgmt_addr)
          9'h021: rv = 32'(pll_locked);
          9'h022: rv = 32'(m_cal);
          9'h041: rv = 32'(m_mask);
          9'h042: rv = {30'd0, (m_rx_left == 0) && (&pll_locked),
                               (m_tx_left == 0) && (&pll_locked)};
          default: rv = 0;
        endcase
      end
      m_rdata = rv;
      if (m_tx_left > 0) m_tx_left--;
      if (m_rx_left > 0) m_rx_left--;
      if (mgmt_write) begin
        case (mgmt_addr)
          9'h022: m_cal = mgmt_wdata[NCH-1:0];
          9'h041: m_mask = mgmt_wdata[NCH-1:0];
          9'h042: begin
            if (mgmt_wdata[0]) begin m_tx_left = NRST; m_txset = old_mask; end
            if (mgmt_wdata[1]) begin m_rx_left = NRST; m_rxset = old_mask; end
          end
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tx_digital_rst == (m_tx_left > 0 ? m_txset : '0), "R6", "model tx_rst",
          32'(tx_digital_rst), 32'(m_tx_left > 0 ? m_txset : '0));
      chk(rx_digital_rst == (m_rx_left > 0 ? m_rxset : '0), "R7", "model rx_rst",
          32'(rx_digital_rst), 32'(m_rx_left > 0 ? m_rxset : '0));
      chk(cal_pd == m_cal, "R4", "model cal_pd", 32'(cal_pd), 32'(m_cal));
      chk(mgmt_rdata == m_rdata, "R2", "model rdata", mgmt_rdata, m_rdata);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = d; mgmt_write = 1'b1;
    @(negedge clk);
    mgmt_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    mgmt_addr = a; mgmt_read = 1'b1;
    @(negedge clk);
    mgmt_read = 1'b0;
    chk(mgmt_rdata == exp, tag, $sformatf("read 0x%03h", a), mgmt_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nchecks++; nerr++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(tx_digital_rst == 0 && rx_digital_rst == 0, "R1", "reset outputs",
        32'({tx_digital_rst, rx_digital_rst}), 0);
    chk(cal_pd == 0, "R1", "reset cal_pd", 32'(cal_pd), 0);
    chk(mgmt_rdata == 0, "R1", "reset rdata", mgmt_rdata, 0);
    rd(9'h041, 32'hF, "R1");

    // R3: PLL status, read-only
    rd(9'h021, 32'h3, "R3");
    pll_locked = 2'b01;
    rd(9'h021, 32'h1, "R3");
    wr(9'h021, 32'hFFFF_FFFF);
    rd(9'h021, 32'h1, "R3");
    pll_locked = 2'b11;

    // R4: calibration power-down
    wr(9'h022, 32'hFFFF_FFFA);
    chk(cal_pd == 4'hA, "R4", "cal_pd after write", 32'(cal_pd), 32'hA);
    rd(9'h022, 32'hA, "R4");

    // R5: mask
    wr(9'h041, 32'h5);
    rd(9'h041, 32'h5, "R5");

    // R6: TX sequence on channels 0 and 2 only
    wr(9'h042, 32'h1);
    chk(tx_digital_rst == 4'h5, "R6", "tx_rst start", 32'(tx_digital_rst), 32'h5);
    chk(rx_digital_rst == 4'h0, "R6", "rx untouched", 32'(rx_digital_rst), 0);
    rd(9'h042, 32'h2, "R8");            // TX busy, RX ready
    idle(NRST);
    chk(tx_digital_rst == 4'h0, "R6", "tx_rst end", 32'(tx_digital_rst), 0);
    rd(9'h042, 32'h3, "R8");

    // R8: ready needs every PLL locked
    pll_locked = 2'b10;
    rd(9'h042, 32'h0, "R8");
    pll_locked = 2'b11;

    // R7: RX alone, then both
    wr(9'h042, 32'h2);
    chk(rx_digital_rst == 4'h5 && tx_digital_rst == 0, "R7", "rx only",
        32'({tx_digital_rst, rx_digital_rst}), 32'h05);
    rd(9'h042, 32'h1, "R7");
    idle(NRST + 1);
    wr(9'h041, 32'hC);
    wr(9'h042, 32'h3);
    chk(tx_digital_rst == 4'hC && rx_digital_rst == 4'hC, "R7", "both dirs",
        32'({tx_digital_rst, rx_digital_rst}), 32'hCC);
    idle(NRST + 1);

    // R9: restart with a narrower mask
    wr(9'h041, 32'hF);
    wr(9'h042, 32'h1);
    idle(1);
    wr(9'h041, 32'h3);
    wr(9'h042, 32'h1);
    chk(tx_digital_rst == 4'h3, "R9", "restart mask", 32'(tx_digital_rst), 32'h3);
    idle(NRST - 1);
    chk(tx_digital_rst == 4'h3, "R9", "restart full length", 32'(tx_digital_rst), 32'h3);
    idle(1);
    chk(tx_digital_rst == 4'h0, "R9", "restart end", 32'(tx_digital_rst), 0);

    // R6: empty mask still runs the timer but drives nothing
    wr(9'h041, 32'h0);
    wr(9'h042, 32'h1);
    chk(tx_digital_rst == 4'h0, "R6", "empty mask", 32'(tx_digital_rst), 0);
    rd(9'h042, 32'h2, "R6");
    idle(NRST);

    // R10: unmapped writes ignored
    wr(9'h041, 32'h6);
    wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h043, 32'hFFFF_FFFF);
    wr(9'h000, 32'hFFFF_FFFF);
    chk(tx_digital_rst == 0 && rx_digital_rst == 0, "R10", "outputs after unmapped",
        32'({tx_digital_rst, rx_digital_rst}), 0);
    rd(9'h041, 32'h6, "R10");
    rd(9'h022, 32'hA, "R10");
    rd(9'h100, 32'h0, "R2");

    // R11: control write without start bits
    wr(9'h042, 32'hFFFF_FFFC);
    chk(tx_digital_rst == 0 && rx_digital_rst == 0, "R11", "no start",
        32'({tx_digital_rst, rx_digital_rst}), 0);
    rd(9'h042, 32'h3, "R11");

    // R1: reset in mid-sequence
    wr(9'h042, 32'h3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(tx_digital_rst == 0 && rx_digital_rst == 0 && cal_pd == 0, "R1", "mid-run reset",
        32'({cal_pd, tx_digital_rst, rx_digital_rst}), 0);
    rd(9'h041, 32'hF, "R1");
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule